// File: doc/BRIEF.md
# Vector fail-first loop controller

This block sequences a vector operation one element at a time and decides whether the loop ends early. After a start strobe it presents the current element index. An external datapath then returns one 4-bit condition field per element, marked by a valid strobe. The controller picks one bit of that field and optionally inverts it. If the result is true, the loop has failed on that element. The block then shortens the vector length to the failing index and ends the loop. An optional setting lets the new length also count the failing element.

A 5-bit mode field controls the test, and its bits mean different things depending on the instruction's Rc bit. When Rc is 1, two mode bits choose which condition bit to test. When Rc is 0, one of those bits turns on the condition update even though Rc is clear, and the other makes the truncation include the failing element. In that case the tested bit is fixed at the equality position. The block also produces the effective Rc enable and an overflow-enable output for the rest of the pipeline, computed combinationally from the live inputs. The configuration inputs must stay stable while a loop runs.

Top module: `vec_failfirst_ctrl`

## Requirements
- R1: After reset, `elem_idx` is 0, `done` is 0 and `vl_out` is 0.
- R2: A `start` in the idle state sets `elem_idx` to 0. While the loop runs, each cycle with `cr_valid` high advances it by one, and a cycle with `cr_valid` low leaves it unchanged.
- R3: `oe_out` equals `oe_in` when `vec_mode` is 0 and is forced to 0 when `vec_mode` is 1.
- R4: `rc_kind` is encoded as 0 = no Rc, 1 = optional Rc taken from `rc_bit`, 2 = Rc fixed at 1, and 3 = no Rc. `rc_en` is 1 when the kind is 1 and `rc_bit` is 1. Otherwise, in vector mode it equals `ff_mode_bits[4]` for kinds 1 and 2 and is 0 for kinds 0 and 3. Outside vector mode it is 1 only for kind 2.
- R5: `ff_mode_bits[2]` inverts the test: 0 fires on a set bit, 1 fires on a clear bit.
- R6: When the decoded Rc is 1 (kind 1 with `rc_bit` 1), the tested bit is `cr_field[{ff_mode_bits[3], ff_mode_bits[4]}]`, with bit 3 as the index MSB.
- R7: Otherwise the tested bit is `cr_field[2]` (the equality position).
- R8: When the test fires on element i, `vl_out` becomes i + v, where v is `ff_mode_bits[3]` when the decoded Rc is 0 and 0 otherwise. The result is 7 bits wide.
- R9: The test is applied only when `ff_mode` is 1 and `rc_en` is 1. Otherwise no element can truncate the length.
- R10: When the test fires, or the last element's result arrives, `done` is high for exactly one cycle and `elem_idx` returns to 0. The `done` pulse appears the cycle after that result.
- R11: If no element fires, `vl_out` ends equal to the `vl_in` captured at start.
- R12: A start with `vl_in` = 0 raises `done` the cycle after start, with `vl_out` = 0, and examines no condition result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a loop (accepted when idle) |
| vl_in | input | 7 | Vector length for the loop |
| ff_mode | input | 1 | Loop runs in fail-first mode |
| ff_mode_bits | input | 5 | Mode field: invert, select/flags |
| rc_bit | input | 1 | Instruction Rc bit |
| rc_kind | input | 2 | Rc type of the instruction |
| vec_mode | input | 1 | Vector mode active |
| oe_in | input | 1 | Decoded overflow enable |
| cr_valid | input | 1 | Condition result valid for current element |
| cr_field | input | 4 | Condition result of current element |
| elem_idx | output | 7 | Current element index |
| rc_en | output | 1 | Effective Rc enable |
| oe_out | output | 1 | Overflow enable after vector suppression |
| vl_out | output | 7 | Possibly truncated vector length |
| done | output | 1 | One-cycle loop completion pulse |

## Verification
The assertions check on every cycle that `done` never lasts two cycles, that overflow enable is off in vector mode, and that the index stays below the current length while running. They also check that the index is zero when idle, that it holds when no result arrives, that the length never grows during a loop, and that a result cannot shorten the length while the test is disabled. Only the bench's scenarios can show the rest. That includes which condition bit is tested under each Rc reading, the effect of the invert flag, and the exact truncated length with and without the inclusive flag. It also includes the Rc enable table and the timing of `done` for zero-length and full-length loops.

// File: rtl/vec_failfirst_ctrl.sv
module vec_failfirst_ctrl #(
  parameter int VLW = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [VLW-1:0] vl_in,
  input  logic           ff_mode,
  input  logic [4:0]     ff_mode_bits,
  input  logic           rc_bit,
  input  logic [1:0]     rc_kind,
  input  logic           vec_mode,
  input  logic           oe_in,
  input  logic           cr_valid,
  input  logic [3:0]     cr_field,
  output logic [VLW-1:0] elem_idx,
  output logic           rc_en,
  output logic           oe_out,
  output logic [VLW-1:0] vl_out,
  output logic           done
);
  localparam logic [1:0]     KIND_OPT = 2'd1;
  localparam logic [1:0]     KIND_ONE = 2'd2;
  localparam logic [VLW-1:0] STEP     = VLW'(1);

  logic           busy;
  logic [VLW-1:0] idx_q, vl_q;
  logic           done_q;

  wire has_rc  = (rc_kind == KIND_OPT) | (rc_kind == KIND_ONE);
  wire rc_dec  = (rc_kind == KIND_OPT) & rc_bit;
  wire [1:0] sel = rc_dec ? {ff_mode_bits[3], ff_mode_bits[4]} : 2'd2;
  wire vli     = ~rc_dec & ff_mode_bits[3];

  assign rc_en  = rc_dec | (vec_mode ? (has_rc & ff_mode_bits[4]) : (rc_kind == KIND_ONE));
  assign oe_out = oe_in & ~vec_mode;

  wire fire = ff_mode & rc_en & (cr_field[sel] ^ ff_mode_bits[2]);
  wire last = (idx_q + STEP) == vl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      idx_q  <= '0;
      vl_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy) begin
        if (start) begin
          idx_q <= '0;
          vl_q  <= vl_in;
          if (vl_in == '0) done_q <= 1'b1;
          else             busy   <= 1'b1;
        end
      end else if (cr_valid) begin
        if (fire) begin
          vl_q   <= idx_q + {{(VLW-1){1'b0}}, vli};
          idx_q  <= '0;
          busy   <= 1'b0;
          done_q <= 1'b1;
        end else if (last) begin
          idx_q  <= '0;
          busy   <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + STEP;
        end
      end
    end
  end

  assign elem_idx = idx_q;
  assign vl_out   = vl_q;
  assign done     = done_q;
endmodule

// File: rtl/vec_failfirst_ctrl_chk.sv
module vec_failfirst_ctrl_chk #(
  parameter int VLW = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           cr_valid,
  input logic           ff_mode,
  input logic           rc_en,
  input logic           vec_mode,
  input logic           oe_out,
  input logic [VLW-1:0] elem_idx,
  input logic [VLW-1:0] vl_out,
  input logic           done
);
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_idx_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> elem_idx == '0);

  p_oe_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vec_mode |-> !oe_out);

  p_idx_below_vl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> elem_idx < vl_out);

  p_idx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cr_valid) |=> elem_idx == $past(elem_idx));

  p_vl_no_grow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> vl_out <= $past(vl_out));

  p_no_test_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cr_valid && !(ff_mode && rc_en)) |=> vl_out == $past(vl_out));
endmodule

bind vec_failfirst_ctrl vec_failfirst_ctrl_chk #(.VLW(VLW)) u_chk (.*);

// File: tb/vec_failfirst_ctrl_bench.sv
`timescale 1ns/1ps
module vec_failfirst_ctrl_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, start, ff_mode, rc_bit, vec_mode, oe_in, cr_valid;
  logic [6:0] vl_in;
  logic [4:0] ff_mode_bits;
  logic [1:0] rc_kind;
  logic [3:0] cr_field;
  logic [6:0] elem_idx, vl_out;
  logic       rc_en, oe_out, done;

  vec_failfirst_ctrl u_vec_failfirst_ctrl (.*);

  int checks = 0;
  int errors = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit f_dec(bit [1:0] k, bit rc);
    return (k == 2'd1) && rc;
  endfunction

  function automatic bit f_rc(bit [1:0] k, bit rc, bit vec, bit [4:0] m);
    if (f_dec(k, rc)) return 1'b1;
    if (vec) return ((k == 2'd1) || (k == 2'd2)) && m[4];
    return k == 2'd2;
  endfunction

  function automatic int f_sel(bit [1:0] k, bit rc, bit [4:0] m);
    return f_dec(k, rc) ? int'({m[3], m[4]}) : 2;
  endfunction

  function automatic bit f_fire(bit ff, bit [1:0] k, bit rc, bit vec, bit [4:0] m, bit [3:0] cr);
    if (!ff || !f_rc(k, rc, vec, m)) return 1'b0;
    return cr[f_sel(k, rc, m)] ^ m[2];
  endfunction

  task automatic run(int vl, bit [4:0] m, bit rc, bit [1:0] k, bit vec, bit ff, int fire_at);
    int  expvl;
    bit  fired;
    bit  en;
    string tag;
    @(negedge clk);
    vl_in = 7'(vl); ff_mode_bits = m; rc_bit = rc; rc_kind = k; vec_mode = vec; ff_mode = ff;
    oe_in = 1'($urandom);
    start = 1'b1;
    #0.1;
    chk(rc_en == f_rc(k, rc, vec, m), "R4 rc_en", rc_en, f_rc(k, rc, vec, m));
    chk(oe_out == (oe_in & !vec), "R3 oe_out", oe_out, oe_in & !vec);
    @(negedge clk);
    start = 1'b0;
    if (vl == 0) begin
      chk(done == 1'b1, "R12 done", done, 1);
      chk(vl_out == 0, "R12 vl_out", vl_out, 0);
      @(negedge clk);
      chk(done == 1'b0, "R10 pulse", done, 0);
      return;
    end
    en = ff && f_rc(k, rc, vec, m);
    expvl = vl;
    fired = 1'b0;
    for (int e = 0; e < vl; e++) begin
      logic [3:0] cr;
      if ($urandom % 4 == 0) begin
        cr_valid = 1'b0;
        @(negedge clk);
      end
      chk(elem_idx == 7'(e), "R2 index", elem_idx, e);
      chk(done == 1'b0, "R10 early done", done, 0);
      cr = 4'($urandom & $urandom);
      if (e == fire_at) cr[f_sel(k, rc, m)] = ~m[2];
      else if (fire_at >= 0) cr[f_sel(k, rc, m)] = m[2];
      cr_field = cr;
      cr_valid = 1'b1;
      fired = f_fire(ff, k, rc, vec, m, cr);
      @(negedge clk);
      cr_valid = 1'b0;
      if (fired) begin
        expvl = e + int'(!f_dec(k, rc) && m[3]);
        break;
      end
    end
    if (!en) tag = "R9 R11 vl_out";
    else if (fired) tag = f_dec(k, rc) ? "R8 R5 R6 vl_out" : "R8 R5 R7 vl_out";
    else tag = "R11 vl_out";
    chk(done == 1'b1, "R10 done", done, 1);
    chk(vl_out == 7'(expvl), tag, vl_out, expvl);
    chk(elem_idx == 0, "R10 idx reset", elem_idx, 0);
    @(negedge clk);
    chk(done == 1'b0, "R10 pulse", done, 0);
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; start = 1'b0; vl_in = '0; ff_mode = 1'b0; ff_mode_bits = '0;
    rc_bit = 1'b0; rc_kind = '0; vec_mode = 1'b0; oe_in = 1'b0; cr_valid = 1'b0; cr_field = '0;
    repeat (3) @(negedge clk);
    chk(elem_idx == 0, "R1 idx", elem_idx, 0);
    chk(done == 0, "R1 done", done, 0);
    chk(vl_out == 0, "R1 vl_out", vl_out, 0);
    rst_n = 1'b1;

    run(0, 5'b10000, 1'b0, 2'd1, 1'b1, 1'b1, -1);
    run(127, 5'b00000, 1'b0, 2'd0, 1'b1, 1'b1, 5);
    run(8, 5'b10000, 1'b0, 2'd1, 1'b1, 1'b1, 0);
    run(8, 5'b11000, 1'b0, 2'd2, 1'b1, 1'b1, 7);
    run(6, 5'b11100, 1'b0, 2'd1, 1'b1, 1'b1, 3);
    run(6, 5'b01100, 1'b1, 2'd1, 1'b1, 1'b1, 2);
    run(6, 5'b10000, 1'b1, 2'd1, 1'b1, 1'b1, 4);
    run(5, 5'b10000, 1'b0, 2'd1, 1'b1, 1'b1, -1);
    run(5, 5'b11000, 1'b0, 2'd2, 1'b0, 1'b1, 2);
    run(5, 5'b11000, 1'b0, 2'd2, 1'b1, 1'b0, 2);

    for (int n = 0; n < 400; n++) begin
      int fa;
      fa = ($urandom % 3 == 0) ? -1 : int'($urandom % 16);
      run(int'($urandom % 18), 5'($urandom), 1'($urandom), 2'($urandom),
          1'($urandom % 4 != 0), 1'($urandom % 5 != 0), fa);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule